// File: doc/BRIEF.md
# Serial-In Latched Parallel-Out Register

This block is an 8-stage serial-to-parallel converter with a separate holding stage. Bits arrive one per rising edge of a shift clock and march through a chain of stages. A second, independent capture clock copies the whole chain into a storage register in one step, so the parallel outputs change only when the system decides a full word is ready, never while bits are still moving.

The shift chain can be emptied at any moment by an active-low asynchronous clear, which leaves the storage register untouched. The last stage of the chain is always visible on a serial cascade output, so several of these blocks can be daisy-chained into a longer register. The parallel outputs are three-state: an active-low output enable either drives the storage contents or releases the pins to high impedance, with no effect on the data held inside.

Top module: `serial_latch_reg`

## Requirements
- R1: On each rising edge of `shiftClk` (with `clrN` high), `serIn` enters stage 0 and every stage i takes the previous value of stage i-1; stage 7 is the oldest bit.
- R2: `serOut` always equals stage 7 of the shift chain and is driven regardless of `oeN`.
- R3: While `clrN` is low, every shift stage reads 0 at once, without waiting for a clock, and rising edges of `shiftClk` have no effect.
- R4: Asserting `clrN` leaves the storage register, and so the enabled `parOut`, unchanged.
- R5: On each rising edge of `storeClk`, the storage register takes all 8 shift stages in parallel; `parOut[i]` then shows stage i.
- R6: The storage register changes only on `storeClk`; shifting alone does not alter `parOut`.
- R7: When `shiftClk` and `storeClk` rise together, the storage register captures the chain contents from before that shift.
- R8: With `oeN` high, all 8 `parOut` pins are high impedance; with `oeN` low, they drive the storage register.
- R9: Toggling `oeN` changes neither the shift chain nor the storage register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shiftClk | input | 1 | Shift chain clock, rising edge active |
| storeClk | input | 1 | Storage register capture clock, rising edge active |
| clrN | input | 1 | Asynchronous clear of the shift chain, active low |
| serIn | input | 1 | Serial data into stage 0 |
| oeN | input | 1 | Parallel output enable, active low |
| serOut | output | 1 | Cascade output, stage 7 of the chain |
| parOut | inout | 8 | Three-state parallel outputs from the storage register |

## Verification
The hardest situation to reach is the coincident edge of both clocks, since it depends on two unrelated clocks rising at exactly the same instant; the stimulus raises both in the same time step, both in a directed case and whenever the random draw selects both. High impedance cannot be read directly, so the bench places a weak-looking alternate driver of a fixed pattern on the parallel bus whenever the enable is off and checks that the pattern appears unchanged. Clear pulses and enable toggles are scattered through a long random shift/capture sequence so that their independence from the storage register is exercised in many states.

// File: rtl/serial_latch_pkg.sv
package serial_latch_pkg;
  // strobes sent from control to the datapath
  typedef struct packed {
    logic clearAct;  // shift chain held clear
    logic driveEn;   // parallel pins driven
  } latchCtrlT;
endpackage

// File: rtl/serial_latch_ctrl.sv
module serial_latch_ctrl
  import serial_latch_pkg::*;
(
  input  logic      clrN,
  input  logic      oeN,
  output latchCtrlT ctrl
);
  // both controls are active low at the pins
  assign ctrl.clearAct = ~clrN;
  assign ctrl.driveEn  = ~oeN;
endmodule

// File: rtl/serial_latch_dp.sv
module serial_latch_dp
  import serial_latch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         shiftClk,
  input  logic         storeClk,
  input  logic         serIn,
  input  latchCtrlT    ctrl,
  output logic [W-1:0] shiftQ,
  output logic [W-1:0] storeQ,
  output logic         serOut
);
  logic clearAct;
  assign clearAct = ctrl.clearAct;

  // one flop per stage, each with its own asynchronous clear
  for (genvar i = 0; i < W; i++) begin : g_stage
    logic nextBit;
    logic stageQ;
    if (i == 0) begin : g_head
      assign nextBit = serIn;
    end else begin : g_link
      assign nextBit = shiftQ[i-1];
    end
    always_ff @(posedge shiftClk or posedge clearAct) begin
      if (clearAct) stageQ <= 1'b0;
      else          stageQ <= nextBit;
    end
    assign shiftQ[i] = stageQ;
  end

  // storage stage: own clock, no clear; nonblocking read gives pre-shift data
  always_ff @(posedge storeClk) begin
    storeQ <= shiftQ;
  end

  assign serOut = shiftQ[W-1];
endmodule

// File: rtl/serial_latch_reg.sv
module serial_latch_reg
  import serial_latch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         shiftClk,
  input  logic         storeClk,
  input  logic         clrN,
  input  logic         serIn,
  input  logic         oeN,
  output logic         serOut,
  inout  wire  [W-1:0] parOut
);
  latchCtrlT   ctrl;
  logic [W-1:0] shiftQ;
  logic [W-1:0] storeQ;

  serial_latch_ctrl ctrlI (
    .clrN (clrN),
    .oeN  (oeN),
    .ctrl (ctrl)
  );

  serial_latch_dp #(.W(W)) dpI (
    .shiftClk (shiftClk),
    .storeClk (storeClk),
    .serIn    (serIn),
    .ctrl     (ctrl),
    .shiftQ   (shiftQ),
    .storeQ   (storeQ),
    .serOut   (serOut)
  );

  // three-state pin drivers
  assign parOut = ctrl.driveEn ? storeQ : {W{1'bz}};
endmodule

// File: rtl/serial_latch_chk.sv
module serial_latch_chk #(
  parameter int W = 8
) (
  input logic         shiftClk,
  input logic         storeClk,
  input logic         clrN,
  input logic         oeN,
  input logic         serOut,
  input wire  [W-1:0] parOut,
  input logic [W-1:0] shiftQ,
  input logic [W-1:0] storeQ
);
  // counts shift edges since the last clear, saturating at 2
  logic [1:0] armed;
  always_ff @(posedge shiftClk or negedge clrN) begin
    if (!clrN)           armed <= 2'd0;
    else if (armed != 2) armed <= armed + 2'd1;
  end

  // R1
  shift_move_chk: assert property (@(negedge shiftClk) disable iff (!clrN)
    (armed == 2'd2) |-> shiftQ[W-1:1] == $past(shiftQ[W-2:0]));

  // R2
  cascade_chk: assert property (@(negedge shiftClk) disable iff (!clrN)
    (armed == 2'd2) |-> serOut == $past(shiftQ[W-2]));

  // R3
  clear_zero_chk: assert property (@(negedge shiftClk)
    !clrN |-> (shiftQ == '0 && serOut == 1'b0));

  // R5 R7
  capture_chk: assert property (@(posedge storeClk) disable iff (!clrN)
    1'b1 |=> storeQ == $past(shiftQ));

  // R8
  drive_chk: assert property (@(negedge storeClk) disable iff (!clrN)
    !oeN |-> parOut == storeQ);
endmodule

bind serial_latch_reg serial_latch_chk #(.W(W)) chkI (
  .shiftClk (shiftClk),
  .storeClk (storeClk),
  .clrN     (clrN),
  .oeN      (oeN),
  .serOut   (serOut),
  .parOut   (parOut),
  .shiftQ   (shiftQ),
  .storeQ   (storeQ)
);

// File: tb/serial_latch_reg_test.sv
module serial_latch_reg_test;
  localparam int W = 8;
  localparam logic [W-1:0] FLOAT_PAT = 8'hA5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic shiftClk = 1'b0, storeClk = 1'b0, clrN = 1'b0, serIn = 1'b0, oeN = 1'b1;
  wire         serOut;
  wire [W-1:0] parBus;

  // bench driver that only shows through when the block releases the pins
  assign parBus = oeN ? FLOAT_PAT : {W{1'bz}};

  serial_latch_reg #(.W(W)) uut (
    .shiftClk (shiftClk),
    .storeClk (storeClk),
    .clrN     (clrN),
    .serIn    (serIn),
    .oeN      (oeN),
    .serOut   (serOut),
    .parOut   (parBus)
  );

  logic [W-1:0] shiftM, storeM;
  int checks = 0, errors = 0;

  function automatic logic [W-1:0] shiftNext(logic [W-1:0] cur, logic din);
    return {cur[W-2:0], din};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(bit sh, bit st, bit din);
    serIn = din;
    #1;
    shiftClk = sh;
    storeClk = st;
    if (st) storeM = shiftM;
    if (sh) shiftM = shiftNext(shiftM, din);
    #4;
    shiftClk = 1'b0;
    storeClk = 1'b0;
    #3;
  endtask

  task automatic checkOuts(string req);
    chk({req, " serOut"}, {{(W-1){1'b0}}, serOut}, {{(W-1){1'b0}}, shiftM[W-1]});
    chk({req, " parOut"}, parBus, oeN ? FLOAT_PAT : storeM);
  endtask

  task automatic loadWord(logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) step(1'b1, 1'b0, v[i]);
  endtask

  task automatic clearPulse();
    clrN = 1'b0;
    #2;
    shiftM = '0;
    chk("R3 clear", {{(W-1){1'b0}}, serOut}, '0);
    clrN = 1'b1;
    #2;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    shiftM = '0;
    #2;
    // reset state
    chk("R3 reset serOut", {{(W-1){1'b0}}, serOut}, '0);
    chk("R8 reset float", parBus, FLOAT_PAT);

    // R3: shift clock ignored while clear is low
    serIn = 1'b1;
    repeat (3) begin
      #1 shiftClk = 1'b1;
      #4 shiftClk = 1'b0;
      #3;
    end
    chk("R3 override", {{(W-1){1'b0}}, serOut}, '0);
    clrN = 1'b1;
    #2;
    step(1'b0, 1'b1, 1'b0);
    oeN = 1'b0;
    #2;
    chk("R3 override stages", parBus, 8'h00);

    // R1 R6: shift a word, parallel pins hold
    loadWord(8'hC3);
    checkOuts("R1");
    chk("R6 hold", parBus, 8'h00);

    // R5: capture
    step(1'b0, 1'b1, 1'b0);
    chk("R5 capture", parBus, 8'hC3);

    // R4: clear leaves storage alone
    clrN = 1'b0;
    #2;
    shiftM = '0;
    chk("R4 storage", parBus, 8'hC3);
    chk("R3 async", {{(W-1){1'b0}}, serOut}, '0);
    clrN = 1'b1;
    #2;

    // R7: coincident edges
    loadWord(8'h5A);
    step(1'b1, 1'b1, 1'b1);
    chk("R7 same edge", parBus, 8'h5A);
    checkOuts("R7");

    // R8 R9 R2: enable toggling
    oeN = 1'b1;
    #2;
    chk("R8 float", parBus, FLOAT_PAT);
    chk("R2 cascade enabled-off", {{(W-1){1'b0}}, serOut}, {{(W-1){1'b0}}, shiftM[W-1]});
    for (int k = 0; k < 5; k++) begin
      oeN = ~oeN;
      #2;
    end
    oeN = 1'b0;
    #2;
    chk("R9 storage kept", parBus, 8'h5A);
    step(1'b0, 1'b1, 1'b0);
    chk("R9 chain kept", parBus, 8'hB5);

    // random mix
    for (int n = 0; n < 500; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[15:8] < 8'd10) clearPulse();
      else if (r[15:8] < 8'd40) begin
        oeN = ~oeN;
        #2;
      end
      step(r[0], r[1], r[2]);
      checkOuts("R1 R5 R8");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule